// File: doc/BRIEF.md
# Configurable SPI Word Shift Engine

This block is a single-lane SPI master that moves one word per transfer. A host loads a 14-bit mode word that selects clock phase, idle clock level, bit order, internal loopback, word length and a two-stage clock prescaler. Loading the transmit register while the engine is idle and enabled starts a transfer. The engine drives the serial clock and the outgoing data line, and samples the incoming line. At the end it raises a one-clock completion pulse and updates the receive register.

Short words, up to 16 bits, sit at fixed places inside the 32-bit transmit and receive registers, and those places depend on the bit order. A 32-bit word uses the whole register as it is. Chip-select generation is left to the surrounding logic.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, the outputs are busy=0, done=0, sck=0, mosi=0 and rx_data=0.
- R2: The mode word has these fields: bit 0 enable, bit 1 phase, bit 2 idle-high, bit 3 msb-first, bit 4 loopback, bit 5 slow prescale, bits 9:6 length code, bits 13:10 prescale modulus PM. Length code 0 selects 32 bits. Codes 3 to 15 select code+1 bits. Codes 1 and 2 are raised to 4 bits. A transfer makes exactly that many sampling edges.
- R3: With slow prescale clear, each sck half-period lasts 2*(PM+1) input clocks. With it set, each half-period lasts 32*(PM+1) input clocks.
- R4: sck rests at the idle-high level whenever no transfer is running. With phase clear, data is sampled on the first edge of each bit. With phase set, data is sampled on the second edge, and mosi changes on the first.
- R5: When msb-first is set, the transmitted bits run from register bit 31 downward. When it is clear, they run from bit 0 upward. A transfer emits exactly the selected number of bits.
- R6: For words up to 16 bits, an msb-first word is returned with its LSB at rx_data bit 16, and an lsb-first word is returned with its MSB at bit 15. Every other bit reads 0. A 32-bit word is returned unshifted. rx_data changes only when done is high.
- R7: When loopback is set, the engine samples its own mosi and ignores miso. When loopback is clear, it samples miso.
- R8: done is high for exactly one input clock, one clock after the last sampling edge, in the same cycle that rx_data takes the new word.
- R9: A transmit write starts a transfer only when the engine is enabled and idle. A transmit write during a transfer, or while the engine is disabled, has no effect.
- R10: A mode write with enable clear stops any transfer at once: sck returns to idle and no done follows. A mode write with enable set is ignored while a transfer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 14 | Mode word value |
| tx_we | input | 1 | Transmit register write strobe |
| tx_wdata | input | 32 | Transmit register value |
| rx_data | output | 32 | Receive register, aligned per R6 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Three situations are hard to reach from the ports: a transfer stopped partway through, a transmit write that lands while a word is in flight, and a mode change attempted during a transfer. The stimulus produces each one by starting a slow transfer and then writing on a chosen cycle while busy is high. It then confirms at the ports that the idle level and the alignment did not change. To tell apart the two sources of received data, the bench feeds miso with the inverse of mosi. A loopback word then comes back equal to the transmitted word, and a word read from miso comes back complemented. Capturing mosi at each sampling edge also confirms the bit order and the bit count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef struct packed {
      logic [3:0] pm;
      logic [3:0] len_code;
      logic       slow;
      logic       loopback;
      logic       msb_first;
      logic       idle_high;
      logic       phase;
      logic       enable;
   } eng_mode_t;

   localparam int MODE_W     = $bits(eng_mode_t);
   localparam int LEN_CODE_W = 4;
   localparam int PM_FIELD_W = 4;
   localparam int MIN_LEN    = 4;

endpackage

// File: rtl/spi_eng_prescaler.sv
module spi_eng_prescaler #(
   parameter int SLOW_DIV = 16,
   parameter int PM_W     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reload,
   input  logic            run,
   input  logic            slow,
   input  logic [PM_W-1:0] pm,
   output logic            tick
);
   localparam int FAST_HALF = 2;
   localparam int SLOW_HALF = 2 * SLOW_DIV;
   localparam int CNT_W     = $clog2(SLOW_HALF * (2 ** PM_W)) + 1;

   if (SLOW_DIV < 2) begin : g_bad_div
      $error("SLOW_DIV must be at least 2");
   end

   logic [CNT_W-1:0] mult;
   logic [CNT_W-1:0] half_m1;
   logic [CNT_W-1:0] cnt;

   assign mult = CNT_W'(pm) + CNT_W'(1);

   if ((SLOW_DIV & (SLOW_DIV - 1)) == 0) begin : g_pow2
      always_comb begin
         if (slow) half_m1 = (mult << $clog2(SLOW_HALF)) - CNT_W'(1);
         else      half_m1 = (mult << 1) - CNT_W'(1);
      end
   end else begin : g_generic
      always_comb begin
         if (slow) half_m1 = mult * CNT_W'(SLOW_HALF) - CNT_W'(1);
         else      half_m1 = mult * CNT_W'(FAST_HALF) - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (reload)     cnt <= half_m1;
      else if (run) begin
         if (cnt == '0)    cnt <= half_m1;
         else              cnt <= cnt - CNT_W'(1);
      end
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter #(
   parameter int WORD_W = 32,
   parameter int EDGE_W = $clog2(2 * WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic              tick,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              phase,
   input  logic              msb_first,
   input  logic              loopback,
   input  logic [EDGE_W-1:0] nbits,
   input  logic              miso,
   output logic              busy,
   output logic              sck_act,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_shreg,
   output logic              last_sample
);
   logic [WORD_W-1:0] tx_sr;
   logic [EDGE_W-1:0] edge_idx;
   logic [EDGE_W:0]   last_full;
   logic [EDGE_W-1:0] last_edge;
   logic [EDGE_W-1:0] bit_idx;
   logic              leading, sample_now, drive_now, in_bit;

   assign last_full  = {nbits, 1'b0} - (EDGE_W + 1)'(1);
   assign last_edge  = last_full[EDGE_W-1:0];
   assign bit_idx    = {1'b0, edge_idx[EDGE_W-1:1]};
   assign leading    = ~edge_idx[0];
   assign sample_now = phase ? ~leading : leading;
   assign drive_now  = phase ? leading : (~leading && (edge_idx != last_edge));
   assign in_bit     = loopback ? mosi : miso;

   function automatic logic head_bit(input logic [WORD_W-1:0] v, input logic msb);
      return msb ? v[WORD_W-1] : v[0];
   endfunction

   function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] v, input logic msb);
      return msb ? (v << 1) : (v >> 1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         sck_act     <= 1'b0;
         mosi        <= 1'b0;
         tx_sr       <= '0;
         rx_shreg    <= '0;
         edge_idx    <= '0;
         last_sample <= 1'b0;
      end else begin
         last_sample <= 1'b0;
         if (abort) begin
            busy    <= 1'b0;
            sck_act <= 1'b0;
         end else if (start) begin
            busy     <= 1'b1;
            sck_act  <= 1'b0;
            edge_idx <= '0;
            rx_shreg <= '0;
            if (!phase) begin
               mosi  <= head_bit(tx_word, msb_first);
               tx_sr <= advance(tx_word, msb_first);
            end else begin
               tx_sr <= tx_word;
            end
         end else if (busy && tick) begin
            sck_act <= ~sck_act;
            if (sample_now) begin
               if (msb_first) rx_shreg <= {rx_shreg[WORD_W-2:0], in_bit};
               else           rx_shreg <= {in_bit, rx_shreg[WORD_W-1:1]};
               if (bit_idx == nbits - EDGE_W'(1)) last_sample <= 1'b1;
            end
            if (drive_now) begin
               mosi  <= head_bit(tx_sr, msb_first);
               tx_sr <= advance(tx_sr, msb_first);
            end
            if (edge_idx == last_edge) busy <= 1'b0;
            else                       edge_idx <= edge_idx + EDGE_W'(1);
         end
      end
   end
endmodule

// File: rtl/spi_eng_rx_align.sv
module spi_eng_rx_align #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] rx_shreg,
   input  logic              msb_first,
   input  logic              full_word,
   output logic [WORD_W-1:0] aligned
);
   localparam int HALF = WORD_W / 2;

   always_comb begin
      if (full_word)      aligned = rx_shreg;
      else if (msb_first) aligned = rx_shreg << HALF;
      else                aligned = rx_shreg >> HALF;
   end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
   import spi_eng_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int SLOW_DIV = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [13:0]       mode_wdata,
   input  logic              tx_we,
   input  logic [WORD_W-1:0] tx_wdata,
   output logic [WORD_W-1:0] rx_data,
   output logic              busy,
   output logic              done,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   localparam int EDGE_W = $clog2(2 * WORD_W);

   if (WORD_W != 2 * (2 ** LEN_CODE_W)) begin : g_bad_width
      $error("WORD_W must be twice the longest short word");
   end
   if (MODE_W != 14) begin : g_bad_mode
      $error("mode word layout must be 14 bits");
   end

   eng_mode_t         mode_q;
   eng_mode_t         mode_in;
   logic              abort, start, sck_act, last_sample;
   logic [EDGE_W-1:0] nbits;
   logic [WORD_W-1:0] rx_shreg, rx_aligned;
   logic              tick;

   assign mode_in = eng_mode_t'(mode_wdata);
   assign abort   = mode_we && !mode_in.enable;
   assign start   = tx_we && mode_q.enable && !busy && !abort;

   always_comb begin
      if (mode_q.len_code == '0)
         nbits = EDGE_W'(WORD_W);
      else if (mode_q.len_code < LEN_CODE_W'(MIN_LEN - 1))
         nbits = EDGE_W'(MIN_LEN);
      else
         nbits = EDGE_W'(mode_q.len_code) + EDGE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         done    <= 1'b0;
         rx_data <= '0;
      end else begin
         if (mode_we && (!busy || !mode_in.enable)) mode_q <= mode_in;
         done <= last_sample;
         if (last_sample) rx_data <= rx_aligned;
      end
   end

   spi_eng_prescaler #(.SLOW_DIV(SLOW_DIV), .PM_W(PM_FIELD_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .reload(start), .run(busy),
      .slow(mode_q.slow), .pm(mode_q.pm), .tick(tick)
   );

   spi_eng_shifter #(.WORD_W(WORD_W), .EDGE_W(EDGE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tick(tick),
      .tx_word(tx_wdata), .phase(mode_q.phase), .msb_first(mode_q.msb_first),
      .loopback(mode_q.loopback), .nbits(nbits), .miso(miso),
      .busy(busy), .sck_act(sck_act), .mosi(mosi), .rx_shreg(rx_shreg),
      .last_sample(last_sample)
   );

   spi_eng_rx_align #(.WORD_W(WORD_W)) u_align (
      .rx_shreg(rx_shreg), .msb_first(mode_q.msb_first),
      .full_word(mode_q.len_code == '0), .aligned(rx_aligned)
   );

   assign sck = sck_act ^ mode_q.idle_high;
endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk #(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              sck,
   input logic              idle_high,
   input logic              enable,
   input logic              tx_we,
   input logic [WORD_W-1:0] rx_data
);
   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck == idle_high); // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy, 2)); // R8
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rx_data)); // R6
   AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_we && !enable && !busy) |=> !busy); // R9
   AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(tx_we)); // R9
endmodule

bind spi_word_engine spi_word_engine_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .sck(sck),
   .idle_high(mode_q.idle_high), .enable(mode_q.enable), .tx_we(tx_we),
   .rx_data(rx_data)
);

// File: tb/spi_word_engine_test.sv
module spi_word_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [13:0] mode_wdata = '0;
   logic        tx_we = 1'b0;
   logic [31:0] tx_wdata = '0;
   logic [31:0] rx_data;
   logic        busy, done, sck, mosi, miso;

   always #10 clk = ~clk;
   assign miso = ~mosi;

   spi_word_engine uut (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_data(rx_data), .busy(busy),
      .done(done), .sck(sck), .mosi(mosi), .miso(miso)
   );

   function automatic logic [13:0] mk(bit en, bit cpha, bit cpol, bit msb, bit loopb,
                                      bit slow, logic [3:0] len, logic [3:0] pm);
      return {pm, len, slow, loopb, msb, cpol, cpha, en};
   endfunction

   localparam int NV = 9;
   localparam logic [13:0] T_MODE [NV] = '{
      mk(1,0,0,1,1,0,4'd7,4'd0),  mk(1,0,0,1,0,0,4'd7,4'd0),
      mk(1,1,0,0,1,0,4'd7,4'd0),  mk(1,0,1,0,0,0,4'd11,4'd1),
      mk(1,1,1,1,1,0,4'd15,4'd0), mk(1,0,0,1,0,0,4'd0,4'd0),
      mk(1,1,0,0,1,0,4'd0,4'd0),  mk(1,0,1,1,0,0,4'd3,4'd0),
      mk(1,1,1,0,1,0,4'd1,4'd0)};
   localparam logic [31:0] T_TX [NV] = '{
      32'hA5123456, 32'hA5123456, 32'hFFFF003C, 32'h12345ABC, 32'hBEEF0000,
      32'h0F0F1234, 32'h80000001, 32'h90000000, 32'hFFFFFFF5};
   localparam logic [31:0] T_RX [NV] = '{
      32'h00A50000, 32'h005A0000, 32'h00003C00, 32'h00005430, 32'hBEEF0000,
      32'hF0F0EDCB, 32'h80000001, 32'h00060000, 32'h00005000};
   localparam logic [31:0] T_WORD [NV] = '{
      32'hA5, 32'hA5, 32'h3C, 32'hABC, 32'hBEEF, 32'h0F0F1234, 32'h80000001,
      32'h9, 32'h5};
   localparam int T_N [NV] = '{8, 8, 8, 12, 16, 32, 32, 4, 4};

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit finished = 0;
   int edges, samples, done_cnt, done_gap, last_samp_cyc, e0, e1;
   logic [31:0] cap;
   logic prev_sck = 1'b0;
   bit cur_cpha, cur_cpol, cur_msb;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      bit lead;
      if (sck !== prev_sck) begin
         if (edges == 0) e0 = cyc;
         if (edges == 1) e1 = cyc;
         edges++;
         lead = (sck != cur_cpol);
         if (lead != cur_cpha) begin
            if (cur_msb) cap = {cap[30:0], mosi};
            else         cap = cap | (32'(mosi) << samples);
            samples++;
            last_samp_cyc = cyc;
         end
      end
      prev_sck = sck;
      if (done === 1'b1) begin
         done_cnt++;
         done_gap = cyc - last_samp_cyc;
      end
   end

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_mon();
      edges = 0; samples = 0; cap = '0; done_cnt = 0; done_gap = -1;
      last_samp_cyc = 0; e0 = 0; e1 = 0; prev_sck = sck;
   endtask

   task automatic set_cur(logic [13:0] m);
      cur_cpha = m[1]; cur_cpol = m[2]; cur_msb = m[3];
   endtask

   task automatic write_mode(logic [13:0] m);
      @(posedge clk); #5 mode_we = 1'b1; mode_wdata = m;
      @(posedge clk); #5 mode_we = 1'b0;
   endtask

   task automatic write_tx(logic [31:0] d);
      @(posedge clk); #5 tx_we = 1'b1; tx_wdata = d;
      @(posedge clk); #5 tx_we = 1'b0;
   endtask

   task automatic wait_idle(int max_cyc);
      for (int i = 0; i < max_cyc && busy; i++) begin
         @(posedge clk); #5;
      end
   endtask

   task automatic wait_done(int max_cyc);
      for (int i = 0; i < max_cyc && done_cnt == 0; i++) begin
         @(posedge clk); #5;
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      logic [31:0] keep_rx;
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      @(posedge clk); #5;
      // R1 reset state
      check(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
      check(sck == 0 && mosi == 0, "R1", "sck/mosi after reset", {sck, mosi}, 0);
      check(rx_data == 0, "R1", "rx_data after reset", rx_data, 0);

      // vector table
      for (int v = 0; v < NV; v++) begin
         write_mode(T_MODE[v]);
         set_cur(T_MODE[v]);
         clear_mon();
         write_tx(T_TX[v]);
         wait_done(3000);
         check(rx_data == T_RX[v], T_MODE[v][4] ? "R7" : "R6", "rx_data word", rx_data, T_RX[v]);
         check(done_gap == 1, "R8", "done after last sample", done_gap, 1);
         wait_idle(3000);
         @(posedge clk); #5;
         check(cap == T_WORD[v], "R5", "mosi bit sequence", cap, T_WORD[v]);
         check(samples == T_N[v], "R2", "sampling edges", samples, T_N[v]);
         check(edges == 2 * T_N[v] && sck == cur_cpol, "R4", "edges and idle level",
               edges, 2 * T_N[v]);
         check(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
      end

      // R3 fast prescale PM=2
      write_mode(mk(1,0,0,1,1,0,4'd3,4'd2)); set_cur(mk(1,0,0,1,1,0,4'd3,4'd2));
      clear_mon(); write_tx(32'h50000000); wait_done(3000); wait_idle(3000);
      check(e1 - e0 == 6, "R3", "fast half period", e1 - e0, 6);
      check(rx_data == 32'h00050000, "R3", "rx after PM=2", rx_data, 32'h00050000);

      // R3 slow prescale PM=1
      write_mode(mk(1,0,0,1,1,1,4'd3,4'd1)); set_cur(mk(1,0,0,1,1,1,4'd3,4'd1));
      clear_mon(); write_tx(32'hA0000000); wait_done(3000); wait_idle(3000);
      check(e1 - e0 == 64, "R3", "slow half period", e1 - e0, 64);

      // R9 transmit write during busy is ignored
      write_mode(mk(1,0,0,1,1,0,4'd7,4'd0)); set_cur(mk(1,0,0,1,1,0,4'd7,4'd0));
      clear_mon(); write_tx(32'hC3000000);
      repeat (3) @(posedge clk);
      write_tx(32'h3C000000);
      wait_done(3000); wait_idle(3000);
      repeat (100) @(posedge clk); #5;
      check(rx_data == 32'h00C30000, "R9", "rx keeps first word", rx_data, 32'h00C30000);
      check(done_cnt == 1 && busy == 0, "R9", "no second transfer", done_cnt, 1);

      // R9 transmit write while disabled
      write_mode(mk(0,0,0,1,1,0,4'd7,4'd0)); set_cur(mk(0,0,0,1,1,0,4'd7,4'd0));
      clear_mon(); write_tx(32'hFF000000);
      repeat (10) @(posedge clk); #5;
      check(busy == 0 && edges == 0, "R9", "disabled write starts nothing", edges, 0);

      // R10 disable aborts a running transfer
      write_mode(mk(1,0,1,1,1,0,4'd15,4'd3)); set_cur(mk(1,0,1,1,1,0,4'd15,4'd3));
      keep_rx = rx_data;
      clear_mon(); write_tx(32'h12340000);
      repeat (40) @(posedge clk);
      write_mode(mk(0,0,1,1,1,0,4'd15,4'd3));
      check(busy == 0 && sck == 1, "R10", "abort stops at idle", {busy, sck}, 32'h1);
      repeat (600) @(posedge clk); #5;
      check(done_cnt == 0 && rx_data == keep_rx, "R10", "no done after abort", done_cnt, 0);

      // R10 mode write with enable set during busy is ignored
      write_mode(mk(1,0,0,1,1,0,4'd7,4'd0)); set_cur(mk(1,0,0,1,1,0,4'd7,4'd0));
      clear_mon(); write_tx(32'h96000000);
      repeat (3) @(posedge clk);
      write_mode(mk(1,0,1,0,1,0,4'd7,4'd0));
      wait_done(3000); wait_idle(3000); @(posedge clk); #5;
      check(rx_data == 32'h00960000, "R10", "alignment unchanged", rx_data, 32'h00960000);
      check(sck == 0, "R10", "idle level unchanged", sck, 0);

      summary();
      $finish;
   end
endmodule